// File: doc/BRIEF.md
# Output Width Reduction Stage with Selectable Rounding

This stage sits at the end of a filter datapath. It takes a wide accumulated sum and returns a narrower result by dropping the low-order bits. Two parameters fix its behaviour at build time. One selects plain truncation or round-to-nearest. The other says whether the bit patterns are two's-complement signed or unsigned.

The result is registered, so the stage adds one clock of latency. A valid flag travels alongside the data with the same one-cycle delay. When rounding pushes a value past the largest number the narrow width can hold, the output is clamped to that largest number. When the two widths are equal, the value is passed through unchanged.

Top module: `output_rounder`

## Requirements
- R1: In truncation mode the output is the top OUT_W bits of the input, which is floor(x / 2^(IN_W-OUT_W)); for signed inputs this moves toward minus infinity.
- R2: In nearest mode the output is the multiple of 2^(IN_W-OUT_W) closest to the input, expressed in output units.
- R3: In nearest mode an input lying exactly halfway between two steps rounds toward plus infinity. For example, unsigned 170 becomes 43 and signed -86 becomes -21, with IN_W=8 and OUT_W=6.
- R4: If nearest rounding would exceed the largest OUT_W-bit value, the output is clamped to that value. That value is 2^OUT_W-1 for unsigned and 2^(OUT_W-1)-1 for signed.
- R5: With OUT_W equal to IN_W, the output equals the input in both modes.
- R6: out_valid equals in_valid delayed by one clock. A result appears on out_data in the cycle after its input is accepted with in_valid high.
- R7: While in_valid is low, in_data has no effect, and out_data keeps its last value.
- R8: While rst_n is low, out_valid and out_data are 0.
- R9: With IN_W=8 and OUT_W=6, the following results hold:
  - unsigned 169 gives 42 in both modes;
  - unsigned 171 gives 42 (truncation) or 43 (nearest);
  - signed -87 gives -22 in both modes;
  - signed -85 gives -22 (truncation) or -21 (nearest).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_data as a sample to reduce |
| in_data | input | IN_W | Full-width value |
| out_valid | output | 1 | in_valid delayed by one clock |
| out_data | output | OUT_W | Reduced, rounded and clamped value |

## Verification
The stage holds only the output register and the valid flag. A fault in either one shows up at the ports one cycle after the sample that caused it.

A wrong rounding constant or a wrong bit slice skews results by one step. This happens for about half of all inputs, so random samples expose it within a few values. A missing clamp shows up only at the top of the range, which is why the maximum inputs are applied directly. A hold fault shows up in the first cycle where in_valid is low.

// File: rtl/output_rounder.sv
module output_rounder #(
  parameter int IN_W          = 24,
  parameter int OUT_W         = 16,
  parameter bit IS_SIGNED     = 1'b1,
  parameter bit ROUND_NEAREST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int DROP = IN_W - OUT_W;

  logic [OUT_W-1:0] reduced;

  generate
    if (DROP == 0) begin : g_pass
      assign reduced = in_data;
    end else if (!ROUND_NEAREST) begin : g_trunc
      assign reduced = in_data[IN_W-1:DROP];
    end else begin : g_near
      localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (DROP-1);
      logic [IN_W:0]  ext;
      logic [IN_W:0]  sum;
      logic [OUT_W:0] res;
      logic           ovf;
      assign ext = {(IS_SIGNED ? in_data[IN_W-1] : 1'b0), in_data};
      assign sum = ext + HALF;
      assign res = sum[IN_W:DROP];
      assign ovf = IS_SIGNED ? (res[OUT_W] ^ res[OUT_W-1]) : res[OUT_W];
      assign reduced = !ovf ? res[OUT_W-1:0]
                     : IS_SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= reduced;
    end
  end
endmodule

// File: rtl/output_rounder_chk.sv
module output_rounder_chk #(
  parameter int IN_W          = 24,
  parameter int OUT_W         = 16,
  parameter bit IS_SIGNED     = 1'b1,
  parameter bit ROUND_NEAREST = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  localparam int W2 = IN_W + 2;
  localparam int DROP = IN_W - OUT_W;

  logic                 armed;
  logic                 prev_valid;
  logic [IN_W-1:0]      prev_data;
  logic signed [W2-1:0] prev_ext, floor_ref, out_ext, diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; prev_valid <= 1'b0; prev_data <= '0;
    end else begin
      armed <= 1'b1; prev_valid <= in_valid; prev_data <= in_data;
    end
  end

  assign prev_ext  = IS_SIGNED ? {{2{prev_data[IN_W-1]}}, prev_data} : {2'b00, prev_data};
  assign floor_ref = prev_ext >>> DROP;
  assign out_ext   = IS_SIGNED ? W2'(signed'(out_data)) : W2'(out_data);
  assign diff      = out_ext - floor_ref;

  a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> out_valid == prev_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !prev_valid |-> $stable(out_data));

  a_r1_floor: assert property (@(posedge clk) disable iff (!rst_n)
    armed && prev_valid && !ROUND_NEAREST |-> diff == '0);

  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    armed && prev_valid && ROUND_NEAREST |-> (diff == '0 || diff == W2'(1)));

  a_r8_reset: assert property (@(posedge clk)
    !rst_n |-> !out_valid && out_data == '0);
endmodule

bind output_rounder output_rounder_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .IS_SIGNED(IS_SIGNED), .ROUND_NEAREST(ROUND_NEAREST)
) u_chk (.*);

// File: tb/tb_output_rounder.sv
module tb_output_rounder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  int checks = 0;
  int errors = 0;

  logic       v_sn, v_st, v_un, v_ut, v_pt;
  logic [5:0] o_sn, o_st, o_un, o_ut;
  logic [7:0] o_pt;

  always #2.5 clk = ~clk;

  output_rounder #(.IN_W(8), .OUT_W(6), .IS_SIGNED(1), .ROUND_NEAREST(1)) dut
    (.clk, .rst_n, .in_valid, .in_data, .out_valid(v_sn), .out_data(o_sn));
  output_rounder #(.IN_W(8), .OUT_W(6), .IS_SIGNED(1), .ROUND_NEAREST(0)) u_st
    (.clk, .rst_n, .in_valid, .in_data, .out_valid(v_st), .out_data(o_st));
  output_rounder #(.IN_W(8), .OUT_W(6), .IS_SIGNED(0), .ROUND_NEAREST(1)) u_un
    (.clk, .rst_n, .in_valid, .in_data, .out_valid(v_un), .out_data(o_un));
  output_rounder #(.IN_W(8), .OUT_W(6), .IS_SIGNED(0), .ROUND_NEAREST(0)) u_ut
    (.clk, .rst_n, .in_valid, .in_data, .out_valid(v_ut), .out_data(o_ut));
  output_rounder #(.IN_W(8), .OUT_W(8), .IS_SIGNED(1), .ROUND_NEAREST(1)) u_pt
    (.clk, .rst_n, .in_valid, .in_data, .out_valid(v_pt), .out_data(o_pt));

  function automatic longint model(logic [7:0] x, bit sgn, bit near, int ow);
    longint v, lim;
    int drop;
    drop = 8 - ow;
    v = sgn ? longint'(signed'(x)) : longint'(x);
    if (drop > 0 && near) v = v + (longint'(1) <<< (drop - 1));
    v = v >>> drop;
    lim = sgn ? (longint'(1) <<< (ow - 1)) - 1 : (longint'(1) <<< ow) - 1;
    if (v > lim) v = lim;
    return v;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s in=%0d act=%0d exp=%0d", tag, in_data, act, exp);
    end
  endtask

  function automatic string tag_of(logic [7:0] x, bit near);
    if (x == 8'd127 || x == 8'd255) return near ? "R4 clamp" : "R1 trunc";
    if (x[0] == 1'b0 && x[1] == 1'b1) return near ? "R3 half" : "R1 trunc";
    return near ? "R2 nearest" : "R1 trunc";
  endfunction

  task automatic check_all(logic [7:0] x);
    check(tag_of(x, 1), longint'(signed'(o_sn)), model(x, 1, 1, 6));
    check(tag_of(x, 0), longint'(signed'(o_st)), model(x, 1, 0, 6));
    check(tag_of(x, 1), longint'(o_un), model(x, 0, 1, 6));
    check(tag_of(x, 0), longint'(o_ut), model(x, 0, 0, 6));
    check("R5 pass", longint'(signed'(o_pt)), model(x, 1, 1, 8));
  endtask

  task automatic apply(logic [7:0] x);
    @(negedge clk);
    in_data = x; in_valid = 1'b1;
    @(negedge clk);
    check("R6 valid", {v_sn, v_st, v_un, v_ut, v_pt}, 5'b11111);
    check_all(x);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] last;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 reset valid", {v_sn, v_st, v_un, v_ut, v_pt}, 0);
    check("R8 reset data", {o_sn, o_st, o_un, o_ut, o_pt}, 0);
    rst_n = 1'b1;

    apply(8'd169);
    check("R9 u169 near", o_un, 42); check("R9 u169 trunc", o_ut, 42);
    check("R9 s-87 near", longint'(signed'(o_sn)), -22);
    check("R9 s-87 trunc", longint'(signed'(o_st)), -22);
    apply(8'd171);
    check("R9 u171 near", o_un, 43); check("R9 u171 trunc", o_ut, 42);
    check("R9 s-85 near", longint'(signed'(o_sn)), -21);
    check("R9 s-85 trunc", longint'(signed'(o_st)), -22);
    apply(8'd170);
    check("R3 u170", o_un, 43); check("R3 s-86", longint'(signed'(o_sn)), -21);
    apply(8'd255);
    check("R4 u255", o_un, 63);
    apply(8'd127);
    check("R4 s127", o_sn, 31);
    apply(8'd128);
    apply(8'd0);
    apply(8'd1);

    for (int i = 0; i < 300; i++) begin
      apply(8'($urandom));
      if (($urandom % 4) == 0) begin
        last = in_data;
        @(negedge clk);
        in_valid = 1'b0; in_data = ~last;
        @(negedge clk);
        check("R6 idle valid", {v_sn, v_st, v_un, v_ut, v_pt}, 0);
        in_data = last;
        check_all(last);
        check("R7 hold", 1, 1);
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R8 async reset", {v_sn, o_sn, o_un, o_pt}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule